// File: doc/BRIEF.md
# Teletext Request Pulse Generator

This block drives the teletext request pin of a video encoder. An outside timing source supplies, on every pixel clock, a horizontal pixel count, a line count and a flag naming the current field. The block raises its output over a programmed span of pixel positions. It does so only on lines that lie inside a line window, and each field has its own window. A global enable gates all activity.

A mode bit changes what the pin carries. In request mode it carries the request pulse. In clock mode it carries a teletext clock, which is the pixel clock divided by a fixed, parameter-set ratio and gated by the same line window.

Configuration arrives as single-byte writes to a small address space. The 11-bit horizontal positions and the 9-bit line limits are split across byte registers. A dedicated reset write returns all configuration to zero.

Top module: `ttx_req_gen`

## Requirements
- R1: After the synchronous reset `rst`, `ttx_out` is low and every configuration field reads as zero. In that state, setting only the enable bit produces no output on line 0 of field 1 at any pixel position.
- R2: The horizontal rise position is {addr 2 bits [2:0], addr 0 byte} and the fall position is {addr 2 bits [5:3], addr 1 byte}, each 11 bits wide, so positions above 255 are reachable.
- R3: The line limits are 9 bits wide. Their low bytes sit at addr 4 (field 1 first), 5 (field 1 last), 6 (field 2 first) and 7 (field 2 last). Their ninth bits sit in the control byte at addr 3: bit 2 for field 1 first, bit 3 for field 1 last, bit 4 for field 2 first, bit 5 for field 2 last.
- R4: While the enable bit (addr 3 bit 0) is clear, `ttx_out` is low one cycle later, whatever the counters show.
- R5: In request mode (addr 3 bit 1 = 0) inside the window, `ttx_out` goes high on the cycle after `pix_cnt` equals the rise position and low on the cycle after it equals the fall position. Between those matches it holds its value.
- R6: A line is inside the window when first <= `line_cnt` <= last, using the field 1 limits when `field_sel` = 0 and the field 2 limits when `field_sel` = 1. Outside the window `ttx_out` is low one cycle later.
- R7: In request mode, if the fall position is less than or equal to the rise position, no pulse is produced.
- R8: In clock mode (addr 3 bit 1 = 1) inside the window with enable set, `ttx_out` follows a free-running divide-by-`CLK_DIV` square wave with one cycle of latency. The wave is high for the first `CLK_DIV`/2 cycles of each period, counting from reset.
- R9: A write to addr 8 with bit 7 set clears every configuration field to zero from the next cycle on. The divider phase is left untouched.
- R10: Every change of `ttx_out` appears exactly one clock after the input condition that causes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 4 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration byte data |
| pix_cnt | input | 11 | Horizontal pixel position from the timing source |
| line_cnt | input | 9 | Line number from the timing source |
| field_sel | input | 1 | Current field: 0 = field 1, 1 = field 2 |
| ttx_out | output | 1 | Teletext request pulse or gated teletext clock |

## Verification
The main function is tried with a set of configuration vectors. One has a plain low-position pulse with separate field windows. One has rise and fall positions and line limits above one byte, which separates a correct high-byte assembly from a truncated one. Two have fall positions equal to and before the rise position, and one uses clock mode.

For every vector, both fields are swept over lines just outside, at and just inside each window edge. This shows whether the right field's limits are used and whether the limits are inclusive. A cycle-accurate model in the bench, built from the requirements, predicts each output value. Directed steps then clear the enable bit, issue the reset write, and check the post-reset state.

// File: rtl/ttx_pkg.sv
package ttx_pkg;

    localparam int HPOS_W = 11;
    localparam int LINE_W = 9;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 4;
    localparam int HHI_W  = HPOS_W - BYTE_W;

    typedef struct packed {
        logic [LINE_W-1:0] first;
        logic [LINE_W-1:0] last;
    } line_win_t;

    typedef struct packed {
        logic              en;
        logic              clk_mode;
        logic [HPOS_W-1:0] h_rise;
        logic [HPOS_W-1:0] h_fall;
        line_win_t         f1;
        line_win_t         f2;
    } ttx_cfg_t;

    typedef enum logic [ADDR_W-1:0] {
        A_HRISE_LO = 4'd0,
        A_HFALL_LO = 4'd1,
        A_HPOS_HI  = 4'd2,
        A_CTRL     = 4'd3,
        A_F1_FIRST = 4'd4,
        A_F1_LAST  = 4'd5,
        A_F2_FIRST = 4'd6,
        A_F2_LAST  = 4'd7,
        A_SYSRST   = 4'd8
    } ttx_addr_e;

    // control byte bit positions
    localparam int CB_EN     = 0;
    localparam int CB_MODE   = 1;
    localparam int CB_F1F_HI = 2;
    localparam int CB_F1L_HI = 3;
    localparam int CB_F2F_HI = 4;
    localparam int CB_F2L_HI = 5;
    localparam int SYSRST_BIT = 7;

    function automatic logic line_inside(line_win_t w, logic [LINE_W-1:0] ln);
        return (ln >= w.first) && (ln <= w.last);
    endfunction

endpackage

// File: rtl/ttx_cfg_regs.sv
module ttx_cfg_regs
    import ttx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [BYTE_W-1:0]     wdata,
    output ttx_cfg_t              cfg
);

    ttx_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            case (ttx_addr_e'(addr))
                A_HRISE_LO: cfg_q.h_rise[BYTE_W-1:0] <= wdata;
                A_HFALL_LO: cfg_q.h_fall[BYTE_W-1:0] <= wdata;
                A_HPOS_HI: begin
                    cfg_q.h_rise[HPOS_W-1:BYTE_W] <= wdata[HHI_W-1:0];
                    cfg_q.h_fall[HPOS_W-1:BYTE_W] <= wdata[2*HHI_W-1:HHI_W];
                end
                A_CTRL: begin
                    cfg_q.en                 <= wdata[CB_EN];
                    cfg_q.clk_mode           <= wdata[CB_MODE];
                    cfg_q.f1.first[LINE_W-1] <= wdata[CB_F1F_HI];
                    cfg_q.f1.last[LINE_W-1]  <= wdata[CB_F1L_HI];
                    cfg_q.f2.first[LINE_W-1] <= wdata[CB_F2F_HI];
                    cfg_q.f2.last[LINE_W-1]  <= wdata[CB_F2L_HI];
                end
                A_F1_FIRST: cfg_q.f1.first[BYTE_W-1:0] <= wdata;
                A_F1_LAST:  cfg_q.f1.last[BYTE_W-1:0]  <= wdata;
                A_F2_FIRST: cfg_q.f2.first[BYTE_W-1:0] <= wdata;
                A_F2_LAST:  cfg_q.f2.last[BYTE_W-1:0]  <= wdata;
                A_SYSRST: begin
                    if (wdata[SYSRST_BIT]) cfg_q <= '0;
                end
                default: ;
            endcase
        end
    end

    assign cfg = cfg_q;

    // R9
    sysrst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_SYSRST && wdata[SYSRST_BIT]) |=> (cfg == '0));

endmodule

// File: rtl/ttx_line_window.sv
module ttx_line_window
    import ttx_pkg::*;
(
    input  line_win_t          f1_win,
    input  line_win_t          f2_win,
    input  logic [LINE_W-1:0]  line_cnt,
    input  logic               field_sel,
    output logic               win_hit
);

    logic hit_f1, hit_f2;

    always_comb begin
        hit_f1  = line_inside(f1_win, line_cnt);
        hit_f2  = line_inside(f2_win, line_cnt);
        win_hit = field_sel ? hit_f2 : hit_f1;
    end

endmodule

// File: rtl/ttx_clk_div.sv
module ttx_clk_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic phase
);

    localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HALF  = DIV / 2;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign phase = (cnt_q < CNT_W'(HALF));

    // R8
    div_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == LAST) |=> phase);

endmodule

// File: rtl/ttx_req_gen.sv
module ttx_req_gen
    import ttx_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [BYTE_W-1:0]   cfg_wdata,
    input  logic [HPOS_W-1:0]   pix_cnt,
    input  logic [LINE_W-1:0]   line_cnt,
    input  logic                field_sel,
    output logic                ttx_out
);

    ttx_cfg_t cfg;
    logic     win_hit;
    logic     div_phase;
    logic     out_q, out_d;
    logic     span_ok;

    ttx_cfg_regs i_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    ttx_line_window i_win (
        .f1_win    (cfg.f1),
        .f2_win    (cfg.f2),
        .line_cnt  (line_cnt),
        .field_sel (field_sel),
        .win_hit   (win_hit)
    );

    ttx_clk_div #(.DIV(CLK_DIV)) i_div (
        .clk   (clk),
        .rst   (rst),
        .phase (div_phase)
    );

    always_comb begin
        span_ok = cfg.h_fall > cfg.h_rise;
        out_d   = out_q;
        if (!cfg.en || !win_hit)        out_d = 1'b0;
        else if (cfg.clk_mode)          out_d = div_phase;
        else if (!span_ok)              out_d = 1'b0;
        else if (pix_cnt == cfg.h_fall) out_d = 1'b0;
        else if (pix_cnt == cfg.h_rise) out_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= 1'b0;
        else     out_q <= out_d;
    end

    assign ttx_out = out_q;

    // R4
    enable_off_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg.en |=> !ttx_out);

    // R6
    outside_window_chk: assert property (@(posedge clk) disable iff (rst)
        !win_hit |=> !ttx_out);

    // R7
    empty_span_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg.clk_mode && cfg.h_fall <= cfg.h_rise) |=> !ttx_out);

    // R5
    rise_match_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && win_hit && !cfg.clk_mode && cfg.h_fall > cfg.h_rise &&
         pix_cnt == cfg.h_rise) |=> ttx_out);

    // R8
    clock_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && win_hit && cfg.clk_mode) |=> (ttx_out == $past(div_phase)));

endmodule

// File: tb/test_ttx_req_gen.sv
module test_ttx_req_gen;

    localparam int DIV = 4;
    localparam int NV  = 6;
    // rise, fall, f1 first, f1 last, f2 first, f2 last, clock mode
    localparam int VEC [NV][7] = '{
        '{ 10,   20,   5,   7,   8,   9, 0},   // R5 R6
        '{300, 1030, 260, 262,   2, 300, 0},   // R2 R3
        '{ 50,   50,   3,   4,   3,   4, 0},   // R7 equal
        '{ 60,   40,   3,   4,   3,   4, 0},   // R7 reversed
        '{ 10,   30,   3,   4,   5,   6, 1},   // R8
        '{  5,    9,   6,   6,   6,   6, 0}    // R6 single line
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [10:0] pix_cnt = '0;
    logic [8:0]  line_cnt = '0;
    logic        field_sel = 1'b0;
    logic        ttx_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // shadow configuration and model state
    int  s_rise, s_fall, s1f, s1l, s2f, s2l;
    bit  s_en, s_mode;
    bit  m_out;
    int  dcnt;

    always #2 clk = ~clk;

    ttx_req_gen #(.CLK_DIV(DIV)) i_ttx_req_gen (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pix_cnt(pix_cnt), .line_cnt(line_cnt),
        .field_sel(field_sel), .ttx_out(ttx_out)
    );

    always @(posedge clk) begin
        if (rst) dcnt <= 0;
        else     dcnt <= (dcnt + 1) % DIV;
    end

    task automatic clear_shadow();
        s_rise = 0; s_fall = 0; s1f = 0; s1l = 0; s2f = 0; s2l = 0;
        s_en = 0; s_mode = 0;
    endtask

    task automatic apply_write(input int a, input int d);
        case (a)
            0: s_rise = (s_rise & 'h700) | (d & 'hff);
            1: s_fall = (s_fall & 'h700) | (d & 'hff);
            2: begin
                s_rise = (s_rise & 'hff) | ((d & 7) << 8);
                s_fall = (s_fall & 'hff) | (((d >> 3) & 7) << 8);
            end
            3: begin
                s_en = d[0]; s_mode = d[1];
                s1f = (s1f & 'hff) | (((d >> 2) & 1) << 8);
                s1l = (s1l & 'hff) | (((d >> 3) & 1) << 8);
                s2f = (s2f & 'hff) | (((d >> 4) & 1) << 8);
                s2l = (s2l & 'hff) | (((d >> 5) & 1) << 8);
            end
            4: s1f = (s1f & 'h100) | (d & 'hff);
            5: s1l = (s1l & 'h100) | (d & 'hff);
            6: s2f = (s2f & 'h100) | (d & 'hff);
            7: s2l = (s2l & 'h100) | (d & 'hff);
            8: if ((d >> 7) & 1) clear_shadow();
            default: ;
        endcase
    endtask

    function automatic bit model(input int p, input int l, input int f);
        bit win;
        win = f ? (l >= s2f && l <= s2l) : (l >= s1f && l <= s1l);
        if (!s_en || !win)    return 1'b0;
        if (s_mode)           return (dcnt < DIV / 2);
        if (s_fall <= s_rise) return 1'b0;
        if (p == s_fall)      return 1'b0;
        if (p == s_rise)      return 1'b1;
        return m_out;
    endfunction

    // one clock: drive at negedge, predict, step, compare at next negedge
    task automatic cycle(input int p, input int l, input int f, input bit we,
                         input int a, input int d, input string tag);
        bit exp;
        pix_cnt   = 11'(p);
        line_cnt  = 9'(l);
        field_sel = f[0];
        cfg_we    = we;
        cfg_addr  = 4'(a);
        cfg_wdata = 8'(d);
        exp = model(p, l, f);
        @(posedge clk);
        @(negedge clk);
        if (we) apply_write(a, d);
        cfg_we = 1'b0;
        m_out = exp;
        checks++;
        if (ttx_out !== exp) begin
            failures++;
            $display("FAIL %s pix=%0d line=%0d field=%0d actual=%0b expected=%0b",
                     tag, p, l, f, ttx_out, exp);
        end
    endtask

    task automatic wr(input int a, input int d, input string tag);
        cycle(0, 0, 0, 1'b1, a, d, tag);
    endtask

    task automatic load_vec(input int v);
        int ctrl;
        ctrl = (((VEC[v][5] >> 8) & 1) << 5) | (((VEC[v][4] >> 8) & 1) << 4) |
               (((VEC[v][3] >> 8) & 1) << 3) | (((VEC[v][2] >> 8) & 1) << 2) |
               (VEC[v][6] << 1);
        wr(3, ctrl, "R3");
        wr(0, VEC[v][0] & 'hff, "R2");
        wr(1, VEC[v][1] & 'hff, "R2");
        wr(2, ((VEC[v][1] >> 8) << 3) | (VEC[v][0] >> 8), "R2");
        wr(4, VEC[v][2] & 'hff, "R3");
        wr(5, VEC[v][3] & 'hff, "R3");
        wr(6, VEC[v][4] & 'hff, "R3");
        wr(7, VEC[v][5] & 'hff, "R3");
        wr(3, ctrl | 1, "R3");
    endtask

    task automatic sweep_vec(input int v, input string tag);
        int lo, hi;
        int lines [8];
        lo = ((VEC[v][0] < VEC[v][1]) ? VEC[v][0] : VEC[v][1]) - 3;
        hi = ((VEC[v][0] > VEC[v][1]) ? VEC[v][0] : VEC[v][1]) + 3;
        if (lo < 0) lo = 0;
        lines = '{VEC[v][2] - 1, VEC[v][2], VEC[v][3], VEC[v][3] + 1,
                  VEC[v][4] - 1, VEC[v][4], VEC[v][5], VEC[v][5] + 1};
        for (int f = 0; f < 2; f++)
            for (int li = 0; li < 8; li++)
                for (int p = lo; p <= hi; p++)
                    cycle(p, lines[li], f, 1'b0, 0, 0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        clear_shadow();
        m_out = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        checks++;
        if (ttx_out !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset actual=%0b expected=0", ttx_out);
        end
        // R1: zero config, only enable set: no output on line 0, field 1
        wr(3, 1, "R1");
        for (int p = 0; p < 40; p++) cycle(p, 0, 0, 1'b0, 0, 0, "R1");

        // table of configuration vectors, one loop
        for (int v = 0; v < NV; v++) begin
            load_vec(v);
            sweep_vec(v, $sformatf("R5 R6 R10 vec%0d", v));
        end

        // R5 R10: directed latency check on vector 0
        load_vec(0);
        cycle(9, 5, 0, 1'b0, 0, 0, "R10");
        cycle(10, 5, 0, 1'b0, 0, 0, "R5");
        checks++;
        if (ttx_out !== 1'b1) begin
            failures++;
            $display("FAIL R5 rise actual=%0b expected=1", ttx_out);
        end
        for (int p = 11; p <= 20; p++) cycle(p, 5, 0, 1'b0, 0, 0, "R5");
        checks++;
        if (ttx_out !== 1'b0) begin
            failures++;
            $display("FAIL R5 fall actual=%0b expected=0", ttx_out);
        end

        // R4: enable cleared, window and span otherwise valid
        wr(3, 0, "R4");
        for (int p = 0; p < 30; p++) cycle(p, 6, 0, 1'b0, 0, 0, "R4");

        // R8: clock mode toggling over a long stretch
        load_vec(4);
        for (int p = 0; p < 64; p++) cycle(p, 5, 1, 1'b0, 0, 0, "R8");

        // R9: system reset write clears configuration
        load_vec(0);
        wr(8, 'h80, "R9");
        wr(3, 1, "R9");
        for (int l = 0; l < 8; l++)
            for (int p = 0; p < 24; p++) cycle(p, l, 0, 1'b0, 0, 0, "R9");
        checks++;
        if (ttx_out !== 1'b0) begin
            failures++;
            $display("FAIL R9 after clear actual=%0b expected=0", ttx_out);
        end

        finish_run();
    end

endmodule